// File: doc/BRIEF.md
# Frame-Synchronous Scaler Dimension Registers

This block holds the four frame dimensions a video scaler works from: the width and height of the incoming frame and of the frame it produces. Software reaches it over a small address/data bus that runs on its own clock. Each value is stored as the dimension minus one. A write is range-checked before it is accepted, and in 4:2:2 chroma mode it is also parity-checked. A write that fails a check leaves the register as it was and sets a sticky error flag. Software clears that flag by reading a status word.

Accepted values land in shadow registers on the bus clock. A toggle handshake carries them into the pixel clock domain, where they are held in a staging copy. The scaler-facing active outputs load from that copy together, on the first frame-start pulse after the copy is taken. A frame therefore never runs with a mix of old and new settings. While the handshake is in flight, the busy output is high and further bus writes are dropped, so the shadows cannot change under the pixel domain.

Top module: `scaler_param_regs`

## Requirements
- R1: After reset, every dimension register and every active output holds its build-time maximum dimension minus one, and the status word reads 0.
- R2: Byte offsets 0x00, 0x04, 0x08 and 0x0C map to input width, input height, output width and output height. A read returns the shadow value on prm_rdata_o one bus clock after prm_rd_en_i. A read of any other offset returns 0, and a write to any other offset changes nothing.
- R3: A write is accepted only if its value lies in the range 31 to the field's maximum dimension minus one, both ends included. A value outside that range leaves the register unchanged.
- R4: When ycc422_i is 1, a write of an even value to either width register (0x00 or 0x08) is rejected. Height registers are not checked for parity, and when ycc422_i is 0 even widths are accepted.
- R5: A write rejected under R3 or R4 sets bit 0 of the status word at offset 0x10. The bit reads 1 until a status read returns it, and that read clears it.
- R6: prm_busy_o rises on the bus clock after an accepted write and stays high until the pixel domain has acknowledged the copy. A write presented while prm_busy_o is 1 is ignored and sets no error.
- R7: The active outputs change only on a frame_start_i pulse. A pulse with no new settings pending leaves them unchanged.
- R8: On the first frame_start_i pulse after prm_busy_o has fallen, all four active outputs take the shadow values together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| prm_clk_i | input | 1 | Parameter bus clock |
| prm_rst_n_i | input | 1 | Synchronous active-low reset, bus domain |
| pix_clk_i | input | 1 | Pixel clock |
| pix_rst_n_i | input | 1 | Synchronous active-low reset, pixel domain |
| prm_wr_en_i | input | 1 | Write strobe |
| prm_rd_en_i | input | 1 | Read strobe |
| prm_addr_i | input | ADDR_W | Byte offset |
| prm_wdata_i | input | 32 | Write data (dimension minus one) |
| prm_rdata_o | output | 32 | Read data, valid one cycle after the strobe |
| prm_busy_o | output | 1 | Handshake in flight; writes are dropped |
| ycc422_i | input | 1 | 4:2:2 chroma mode, enables the width parity check |
| frame_start_i | input | 1 | One-cycle frame boundary pulse, pixel domain |
| act_in_w_o | output | 32 | Active input width minus one |
| act_in_h_o | output | 32 | Active input height minus one |
| act_out_w_o | output | 32 | Active output width minus one |
| act_out_h_o | output | 32 | Active output height minus one |

## Verification
The assertions assume that ycc422_i is static in the bus domain, that frame_start_i is a single-cycle pulse synchronous to the pixel clock, and that both resets are applied together. They also assume the bus master drives a strobe for exactly one cycle and never drives a read and a write in the same cycle. The stimulus drives every strobe for one bus cycle on the falling edge and never overlaps reads with writes. It changes the chroma mode only between operations, and it pulses frame_start_i for one pixel cycle. Before each frame pulse the bench waits for prm_busy_o to fall, so the expected active values are the shadows it has modelled.

// File: rtl/scaler_prm_pkg.sv
// Shared types and constants for the scaler dimension register block.
package scaler_prm_pkg;

    localparam int          DATA_W   = 32;
    localparam logic [31:0] MIN_CODE = 32'd31;
    localparam int          NUM_DIMS = 4;

    // Field indices follow the byte offset: index = offset / 4.
    localparam logic [7:0] OFS_IN_W   = 8'h00;
    localparam logic [7:0] OFS_IN_H   = 8'h04;
    localparam logic [7:0] OFS_OUT_W  = 8'h08;
    localparam logic [7:0] OFS_OUT_H  = 8'h0C;
    localparam logic [7:0] OFS_STATUS = 8'h10;

    typedef struct packed {
        logic [DATA_W-1:0] in_w;
        logic [DATA_W-1:0] in_h;
        logic [DATA_W-1:0] out_w;
        logic [DATA_W-1:0] out_h;
    } frame_dims_t;

endpackage

// File: rtl/prm_toggle_sync.sv
// Level synchronizer for a handshake toggle.
// Assumes d_i changes at most once per handshake and is held until acknowledged.
// STAGES selects a flop chain; a value of 1 suits a shared clock.
module prm_toggle_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            // Single retiming flop for the shared-clock variant.
            always_ff @(posedge clk_i) begin
                if (!rst_n_i) chain_q <= '0;
                else          chain_q <= d_i;
            end
        end else begin : g_multi
            // Multi-flop chain for an unrelated source clock.
            always_ff @(posedge clk_i) begin
                if (!rst_n_i) chain_q <= '0;
                else          chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/prm_reg_bank.sv
// Bus-domain register bank: address decode, range and parity checks,
// shadow storage, sticky error, and the request side of the handshake.
// Assumes reads and writes are never strobed in the same cycle.
module prm_reg_bank
    import scaler_prm_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          SYNC_STAGES = 2,
    parameter frame_dims_t RST_DIMS    = '0
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              ycc422_i,
    input  logic              ack_tgl_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              busy_o,
    output logic              err_o,
    output logic              req_tgl_o,
    output frame_dims_t       shadow_o
);
    logic [DATA_W-1:0] shadow_q [NUM_DIMS];
    logic [1:0]        field_idx;
    logic              field_hit;
    logic              status_hit;
    logic [DATA_W-1:0] cur_lim;
    logic              value_ok;
    logic              wr_take;
    logic              accept;
    logic              reject;
    logic              ack_sync;
    logic              req_q;
    logic              err_q;

    // Upper limit (and reset value) of a field by index.
    function automatic logic [DATA_W-1:0] lim_of(input logic [1:0] k);
        case (k)
            2'd0:    return RST_DIMS.in_w;
            2'd1:    return RST_DIMS.in_h;
            2'd2:    return RST_DIMS.out_w;
            default: return RST_DIMS.out_h;
        endcase
    endfunction

    // Decode the byte offset into a field index or the status word.
    always_comb begin
        field_idx  = addr_i[3:2];
        field_hit  = 1'b0;
        status_hit = 1'b0;
        if (((addr_i >> 5) == '0) && (addr_i[1:0] == 2'b00)) begin
            if (!addr_i[4])              field_hit  = 1'b1;
            else if (addr_i[3:2] == 2'b00) status_hit = 1'b1;
        end
    end

    // Validate the write value: range always, parity on widths in 4:2:2.
    always_comb begin
        cur_lim  = lim_of(field_idx);
        value_ok = (wdata_i >= MIN_CODE) && (wdata_i <= cur_lim) &&
                   !(ycc422_i && !field_idx[0] && !wdata_i[0]);
    end

    assign wr_take = wr_en_i && !busy_o && field_hit;
    assign accept  = wr_take && value_ok;
    assign reject  = wr_take && !value_ok;

    generate
        for (genvar g = 0; g < NUM_DIMS; g++) begin : g_field
            // Shadow register for one dimension, loaded on an accepted write.
            always_ff @(posedge clk_i) begin
                if (!rst_n_i)
                    shadow_q[g] <= lim_of(2'(g));
                else if (accept && (field_idx == 2'(g)))
                    shadow_q[g] <= wdata_i;
            end
        end
    endgenerate

    // Request toggle flips once per accepted write.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)    req_q <= 1'b0;
        else if (accept) req_q <= ~req_q;
    end

    prm_toggle_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk_i  (clk_i),
        .rst_n_i(rst_n_i),
        .d_i    (ack_tgl_i),
        .q_o    (ack_sync)
    );

    assign busy_o = req_q ^ ack_sync;

    // Sticky error: set by a rejected write, cleared by a status read.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)                   err_q <= 1'b0;
        else if (reject)                err_q <= 1'b1;
        else if (rd_en_i && status_hit) err_q <= 1'b0;
    end

    // Registered read mux: shadows, status, or zero for unmapped offsets.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)
            rdata_o <= '0;
        else if (rd_en_i) begin
            if (field_hit)       rdata_o <= shadow_q[field_idx];
            else if (status_hit) rdata_o <= {{(DATA_W-1){1'b0}}, err_q};
            else                 rdata_o <= '0;
        end
    end

    assign err_o     = err_q;
    assign req_tgl_o = req_q;
    assign shadow_o  = '{in_w: shadow_q[0], in_h: shadow_q[1],
                         out_w: shadow_q[2], out_h: shadow_q[3]};
endmodule

// File: rtl/prm_active_load.sv
// Pixel-domain side: detects a request toggle, copies the stable shadows
// into a staging set, acknowledges, and loads the active set at frame start.
// Assumes the shadows do not change between request and acknowledge.
module prm_active_load
    import scaler_prm_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter frame_dims_t RST_DIMS    = '0
) (
    input  logic        clk_i,
    input  logic        rst_n_i,
    input  logic        req_tgl_i,
    input  frame_dims_t shadow_i,
    input  logic        frame_start_i,
    output logic        ack_tgl_o,
    output frame_dims_t active_o
);
    logic        req_sync;
    logic        req_seen_q;
    logic        new_req;
    logic        pending_q;
    logic        ack_q;
    frame_dims_t stage_q;
    frame_dims_t active_q;

    prm_toggle_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk_i  (clk_i),
        .rst_n_i(rst_n_i),
        .d_i    (req_tgl_i),
        .q_o    (req_sync)
    );

    assign new_req = req_sync ^ req_seen_q;

    // Track the last request level seen, to detect a toggle.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) req_seen_q <= 1'b0;
        else          req_seen_q <= req_sync;
    end

    // Capture the shadows into staging on a new request.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)     stage_q <= RST_DIMS;
        else if (new_req) stage_q <= shadow_i;
    end

    // Return the acknowledge toggle once staging holds the copy.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)     ack_q <= 1'b0;
        else if (new_req) ack_q <= ~ack_q;
    end

    // Pending flag: set by a capture, cleared when the frame boundary consumes it.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)                       pending_q <= 1'b0;
        else if (new_req)                   pending_q <= 1'b1;
        else if (frame_start_i && pending_q) pending_q <= 1'b0;
    end

    // Load all active dimensions together at a frame start with work pending.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)                        active_q <= RST_DIMS;
        else if (frame_start_i && pending_q) active_q <= stage_q;
    end

    assign ack_tgl_o = ack_q;
    assign active_o  = active_q;
endmodule

// File: rtl/scaler_param_regs.sv
// Top of the scaler dimension register block. Wires the bus-domain bank
// to the pixel-domain loader. SEPARATE_CLK=0 assumes both clock pins share
// one clock and shortens the synchronizers to a single flop.
module scaler_param_regs
    import scaler_prm_pkg::*;
#(
    parameter int MAX_IN_W     = 1920,
    parameter int MAX_IN_H     = 1080,
    parameter int MAX_OUT_W    = 1920,
    parameter int MAX_OUT_H    = 1080,
    parameter int ADDR_W       = 8,
    parameter bit SEPARATE_CLK = 1'b1
) (
    input  logic              prm_clk_i,
    input  logic              prm_rst_n_i,
    input  logic              pix_clk_i,
    input  logic              pix_rst_n_i,
    input  logic              prm_wr_en_i,
    input  logic              prm_rd_en_i,
    input  logic [ADDR_W-1:0] prm_addr_i,
    input  logic [31:0]       prm_wdata_i,
    output logic [31:0]       prm_rdata_o,
    output logic              prm_busy_o,
    input  logic              ycc422_i,
    input  logic              frame_start_i,
    output logic [31:0]       act_in_w_o,
    output logic [31:0]       act_in_h_o,
    output logic [31:0]       act_out_w_o,
    output logic [31:0]       act_out_h_o
);
    localparam int          SYNC_STAGES = SEPARATE_CLK ? 2 : 1;
    localparam frame_dims_t RST_DIMS = '{
        in_w:  32'(MAX_IN_W - 1),
        in_h:  32'(MAX_IN_H - 1),
        out_w: 32'(MAX_OUT_W - 1),
        out_h: 32'(MAX_OUT_H - 1)
    };

    frame_dims_t shadow_dims;
    frame_dims_t active_dims;
    logic        req_tgl;
    logic        ack_tgl;
    logic        err_flag;

    prm_reg_bank #(
        .ADDR_W     (ADDR_W),
        .SYNC_STAGES(SYNC_STAGES),
        .RST_DIMS   (RST_DIMS)
    ) u_bank (
        .clk_i    (prm_clk_i),
        .rst_n_i  (prm_rst_n_i),
        .wr_en_i  (prm_wr_en_i),
        .rd_en_i  (prm_rd_en_i),
        .addr_i   (prm_addr_i),
        .wdata_i  (prm_wdata_i),
        .ycc422_i (ycc422_i),
        .ack_tgl_i(ack_tgl),
        .rdata_o  (prm_rdata_o),
        .busy_o   (prm_busy_o),
        .err_o    (err_flag),
        .req_tgl_o(req_tgl),
        .shadow_o (shadow_dims)
    );

    prm_active_load #(
        .SYNC_STAGES(SYNC_STAGES),
        .RST_DIMS   (RST_DIMS)
    ) u_load (
        .clk_i        (pix_clk_i),
        .rst_n_i      (pix_rst_n_i),
        .req_tgl_i    (req_tgl),
        .shadow_i     (shadow_dims),
        .frame_start_i(frame_start_i),
        .ack_tgl_o    (ack_tgl),
        .active_o     (active_dims)
    );

    assign act_in_w_o  = active_dims.in_w;
    assign act_in_h_o  = active_dims.in_h;
    assign act_out_w_o = active_dims.out_w;
    assign act_out_h_o = active_dims.out_h;
endmodule

// File: rtl/scaler_param_regs_chk.sv
// Property checker for scaler_param_regs, attached by bind.
module scaler_param_regs_chk
    import scaler_prm_pkg::*;
#(
    parameter int MAX_IN_W  = 1920,
    parameter int MAX_IN_H  = 1080,
    parameter int MAX_OUT_W = 1920,
    parameter int MAX_OUT_H = 1080,
    parameter int ADDR_W    = 8
) (
    input logic              pclk,
    input logic              prst_n,
    input logic              vclk,
    input logic              vrst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              ycc422,
    input logic              busy,
    input logic              err,
    input frame_dims_t       shadow,
    input logic              frame_start,
    input frame_dims_t       active
);
    // R6
    busy_rise_chk: assert property (@(posedge pclk) disable iff (!prst_n)
        $rose(busy) |-> $past(wr_en));

    // R6
    busy_freeze_chk: assert property (@(posedge pclk) disable iff (!prst_n)
        busy |=> $stable(shadow));

    // R3
    shadow_range_chk: assert property (@(posedge pclk) disable iff (!prst_n)
        shadow.in_w  >= MIN_CODE && shadow.in_w  <= 32'(MAX_IN_W - 1)  &&
        shadow.in_h  >= MIN_CODE && shadow.in_h  <= 32'(MAX_IN_H - 1)  &&
        shadow.out_w >= MIN_CODE && shadow.out_w <= 32'(MAX_OUT_W - 1) &&
        shadow.out_h >= MIN_CODE && shadow.out_h <= 32'(MAX_OUT_H - 1));

    // R4
    width_parity_chk: assert property (@(posedge pclk) disable iff (!prst_n)
        (ycc422 && wr_en && !busy && addr == ADDR_W'(OFS_OUT_W) && !wdata[0])
        |=> $stable(shadow.out_w));

    // R5
    err_clear_chk: assert property (@(posedge pclk) disable iff (!prst_n)
        (rd_en && !wr_en && addr == ADDR_W'(OFS_STATUS)) |=> !err);

    // R7
    active_hold_chk: assert property (@(posedge vclk) disable iff (!vrst_n)
        !frame_start |=> $stable(active));
endmodule

bind scaler_param_regs scaler_param_regs_chk #(
    .MAX_IN_W (MAX_IN_W),
    .MAX_IN_H (MAX_IN_H),
    .MAX_OUT_W(MAX_OUT_W),
    .MAX_OUT_H(MAX_OUT_H),
    .ADDR_W   (ADDR_W)
) u_chk (
    .pclk       (prm_clk_i),
    .prst_n     (prm_rst_n_i),
    .vclk       (pix_clk_i),
    .vrst_n     (pix_rst_n_i),
    .wr_en      (prm_wr_en_i),
    .rd_en      (prm_rd_en_i),
    .addr       (prm_addr_i),
    .wdata      (prm_wdata_i),
    .ycc422     (ycc422_i),
    .busy       (prm_busy_o),
    .err        (err_flag),
    .shadow     (shadow_dims),
    .frame_start(frame_start_i),
    .active     (active_dims)
);

// File: tb/tb_scaler_param_regs.sv
module tb_scaler_param_regs;
    localparam int PRM_CLK_PERIOD = 10;
    localparam int PIX_CLK_PERIOD = 14;
    localparam int MAX_IN_W  = 640;
    localparam int MAX_IN_H  = 480;
    localparam int MAX_OUT_W = 1280;
    localparam int MAX_OUT_H = 720;
    localparam int ADDR_W    = 8;

    logic        pclk = 1'b0, vclk = 1'b0;
    logic        prst_n = 1'b0, vrst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        busy;
    logic        ycc = 1'b0;
    logic        fs = 1'b0;
    logic [31:0] a_iw, a_ih, a_ow, a_oh;

    int n_chk = 0, n_bad = 0;
    logic [31:0] m_sh [4];
    logic        m_err;

    always #(PRM_CLK_PERIOD/2) pclk = ~pclk;
    always #(PIX_CLK_PERIOD/2) vclk = ~vclk;

    scaler_param_regs #(
        .MAX_IN_W(MAX_IN_W), .MAX_IN_H(MAX_IN_H),
        .MAX_OUT_W(MAX_OUT_W), .MAX_OUT_H(MAX_OUT_H),
        .ADDR_W(ADDR_W), .SEPARATE_CLK(1'b1)
    ) dut (
        .prm_clk_i(pclk), .prm_rst_n_i(prst_n),
        .pix_clk_i(vclk), .pix_rst_n_i(vrst_n),
        .prm_wr_en_i(wr_en), .prm_rd_en_i(rd_en),
        .prm_addr_i(addr), .prm_wdata_i(wdata),
        .prm_rdata_o(rdata), .prm_busy_o(busy),
        .ycc422_i(ycc), .frame_start_i(fs),
        .act_in_w_o(a_iw), .act_in_h_o(a_ih),
        .act_out_w_o(a_ow), .act_out_h_o(a_oh)
    );

    function automatic logic [31:0] lim(input int k);
        case (k)
            0: return 32'(MAX_IN_W - 1);
            1: return 32'(MAX_IN_H - 1);
            2: return 32'(MAX_OUT_W - 1);
            default: return 32'(MAX_OUT_H - 1);
        endcase
    endfunction

    function automatic bit is_field(input logic [7:0] a);
        return (a[7:4] == 4'h0) && (a[1:0] == 2'b00);
    endfunction

    function automatic bit val_ok(input int k, input logic [31:0] d, input logic mode);
        return (d >= 32'd31) && (d <= lim(k)) && !(mode && (k % 2 == 0) && !d[0]);
    endfunction

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        logic bz;
        @(negedge pclk);
        bz = busy;
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge pclk);
        wr_en = 1'b0;
        if (!bz && is_field(a)) begin
            if (val_ok(int'(a[3:2]), d, ycc)) m_sh[a[3:2]] = d;
            else                              m_err = 1'b1;
        end
    endtask

    task automatic do_read(input logic [7:0] a, input string tag);
        logic [31:0] exp;
        if (is_field(a))        exp = m_sh[a[3:2]];
        else if (a == 8'h10)    exp = {31'd0, m_err};
        else                    exp = '0;
        @(negedge pclk);
        rd_en = 1'b1; addr = a;
        @(negedge pclk);
        rd_en = 1'b0;
        if (a == 8'h10) m_err = 1'b0;
        check(rdata, exp, tag);
    endtask

    task automatic wait_idle(input string tag);
        int k = 0;
        @(negedge pclk);
        while (busy && k < 200) begin
            @(negedge pclk);
            k++;
        end
        check(32'(busy), 32'd0, tag);
    endtask

    task automatic check_active(input string tag);
        check(a_iw, m_sh[0], tag);
        check(a_ih, m_sh[1], tag);
        check(a_ow, m_sh[2], tag);
        check(a_oh, m_sh[3], tag);
    endtask

    task automatic frame_pulse(input string tag);
        @(negedge vclk); fs = 1'b1;
        @(negedge vclk); fs = 1'b0;
        @(negedge vclk);
        check_active(tag);
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (150000) @(posedge pclk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] old_ih;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 4; k++) m_sh[k] = lim(k);
        m_err = 1'b0;
        repeat (4) @(negedge vclk);
        prst_n = 1'b1; vrst_n = 1'b1;

        // R1: reset values
        for (int k = 0; k < 4; k++) do_read(8'(k * 4), "R1 reset shadow");
        do_read(8'h10, "R1 reset status");
        check_active("R1 reset active");

        // R2 + R7 + R8: accepted write reaches active only at frame start
        do_write(8'h00, 32'd99);
        check(32'(busy), 32'd1, "R6 busy after write");
        wait_idle("R6 busy falls");
        do_read(8'h00, "R2 readback in_w");
        check(a_iw, lim(0), "R7 active held before frame");
        frame_pulse("R8 load at frame start");

        // R3: out of range both sides
        do_write(8'h04, 32'd30);
        do_read(8'h04, "R3 below min ignored");
        do_write(8'h0C, lim(3) + 1);
        do_read(8'h0C, "R3 above max ignored");
        // R5: sticky error clears on read
        do_read(8'h10, "R5 error set");
        do_read(8'h10, "R5 error cleared");

        // R3: exact boundaries accepted
        do_write(8'h04, 32'd31);   wait_idle("R3 idle");
        do_write(8'h08, lim(2));   wait_idle("R3 idle");
        do_read(8'h04, "R3 min accepted");
        do_read(8'h08, "R3 max accepted");

        // R4: parity in 4:2:2 mode
        ycc = 1'b1;
        do_write(8'h08, 32'd100);
        do_read(8'h08, "R4 even width rejected");
        do_read(8'h10, "R4 error on parity");
        do_write(8'h08, 32'd101);  wait_idle("R4 idle");
        do_write(8'h04, 32'd100);  wait_idle("R4 idle");
        do_read(8'h08, "R4 odd width accepted");
        do_read(8'h04, "R4 even height accepted");
        ycc = 1'b0;
        do_write(8'h00, 32'd200);  wait_idle("R4 idle");
        do_read(8'h00, "R4 even width in 4:4:4");

        // R6: back-to-back write dropped while busy, no error
        do_write(8'h04, 32'd200);
        do_write(8'h04, 32'd300);
        wait_idle("R6 idle");
        do_read(8'h04, "R6 write while busy ignored");
        do_read(8'h10, "R6 no error from dropped write");

        // R2: unmapped offsets
        do_write(8'h14, 32'd77);
        do_read(8'h14, "R2 unmapped read zero");
        do_read(8'h02, "R2 misaligned read zero");
        do_read(8'h10, "R2 unmapped write no error");

        frame_pulse("R8 load after several writes");
        // R7: frame pulse with nothing pending
        old_ih = a_ih;
        frame_pulse("R7 no pending no change");
        check(a_ih, old_ih, "R7 stable active");

        // Random phase
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom % 100);
            if (op < 50) begin
                logic [7:0]  a;
                logic [31:0] d;
                int k;
                a = 8'(($urandom % 6) * 4);
                k = int'(a[3:2]);
                case ($urandom % 4)
                    0, 1: d = 32'd31 + ($urandom % (lim(k) - 32'd30));
                    2:    d = $urandom % 32'd31;
                    default: d = lim(k) + 1 + ($urandom % 32'd200);
                endcase
                do_write(a, d);
            end else if (op < 80) begin
                do_read(8'(($urandom % 6) * 4), "R2 random read");
            end else if (op < 90) begin
                wait_idle("R6 random idle");
                frame_pulse("R8 random frame");
            end else begin
                wait_idle("R6 random idle");
                ycc = 1'($urandom % 2);
            end
        end
        wait_idle("R6 final idle");
        frame_pulse("R8 final frame");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule